// File: doc/BRIEF.md
# BF16 Vector Greater-Than to Byte Predicate

This block takes two 1024-bit vectors, each holding 64 bfloat16 lanes, and compares them lane by lane with a floating-point greater-than test. Each lane covers two bytes of the vector, so its boolean result is widened to a two-bit mask. The masks are placed into a 128-bit byte-granular predicate. A 6-bit minor opcode chooses how the new masks are written. They can overwrite the predicate, or they can be merged with the current predicate value by AND, OR or XOR.

The compare treats every bf16 operand as the upper half of an fp32 number whose low 16 bits are zero. Greater-than therefore follows IEEE ordering. NaNs are unordered, and the two signed zeros are equal. An opcode outside the four defined codes passes the old predicate through unchanged and raises an illegal-opcode flag. The datapath is combinational. By default a single output register stage sits behind it; this stage is selected by a parameter.

Top module: `bf16_vcmp_pred`

## Requirements
- R1: Lane i occupies vector bits [16i+15:16i] and owns predicate bits 2i and 2i+1. Its result is a > b, evaluated as fp32 greater-than on the operands extended with 16 zero bits below.
- R2: With opcode 011110 (assign), both predicate bits of a lane become 1 when its compare is true and 0 when it is false.
- R3: With opcode 110100, each new predicate bit is the old bit ANDed with the lane's compare mask.
- R4: With opcode 001110, each new predicate bit is the old bit ORed with the lane's compare mask.
- R5: With opcode 111100, each new predicate bit is the old bit XORed with the lane's compare mask.
- R6: If either operand is a NaN (exponent 0xFF with a nonzero fraction), the compare is false.
- R7: +0 and -0 are equal, and equal operands never compare greater.
- R8: For any other opcode, the output predicate equals the input predicate and illegal_op is 1. For the four defined opcodes, illegal_op is 0.
- R9: With REG_OUT=1, results appear one clock after the inputs. A synchronous active-low reset clears pred_out and illegal_op to 0.
- R10: Ordering follows the sign and magnitude. A less negative value is greater than a more negative one. +inf is greater than any finite value, and -inf is less than any finite value. Denormals order by magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_a | input | 1024 | Left-hand operand vector, 64 bf16 lanes |
| vec_b | input | 1024 | Right-hand operand vector, 64 bf16 lanes |
| pred_in | input | 128 | Current predicate value |
| minor_op | input | 6 | Mode select opcode |
| pred_out | output | 128 | New predicate value |
| illegal_op | output | 1 | High when minor_op is not one of the four defined codes |

## Verification
The block holds no state beyond the output register. A wrong lane decision, a swapped mask bit or a misdecoded mode therefore shows up in pred_out on the very next clock after the inputs that trigger it. A fault in the sign, NaN or zero handling shows only for operand pairs that reach that branch. The stimulus therefore places each corner-case pair on a different subset of lanes. Misplaced lanes and single-bit mask errors appear as a wrong bit pair in the 128-bit word.

// File: rtl/bf16cmp_pkg.sv
// Shared types for the bf16 vector compare block.
// Assumes the minor opcode has already been extracted into a 6-bit field.
package bf16cmp_pkg;
    typedef enum logic [1:0] {
        MODE_SET = 2'd0,
        MODE_AND = 2'd1,
        MODE_OR  = 2'd2,
        MODE_XOR = 2'd3
    } pmode_e;

    localparam int OP_W = 6;
    localparam logic [OP_W-1:0] OPC_SET = 6'b011110;
    localparam logic [OP_W-1:0] OPC_AND = 6'b110100;
    localparam logic [OP_W-1:0] OPC_OR  = 6'b001110;
    localparam logic [OP_W-1:0] OPC_XOR = 6'b111100;
endpackage

// File: rtl/bf16_lane_gt.sv
// One-lane floating-point greater-than on a sign/exponent/fraction value.
// Padding the operand with zero low bits does not change its order, so the
// fp32 test is done directly on the narrow encoding. NaN gives false, and
// the two zeros are equal.
module bf16_lane_gt #(
    parameter int WIDTH = 16,
    parameter int EXP_W = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             a_gt_b
);
    localparam int FRAC_W = WIDTH - 1 - EXP_W;

    logic             sgn_a, sgn_b;
    logic [WIDTH-2:0] mag_a, mag_b;
    logic             nan_a, nan_b, both_zero;

    // Split the fields and classify the special values.
    always_comb begin
        sgn_a     = op_a[WIDTH-1];
        sgn_b     = op_b[WIDTH-1];
        mag_a     = op_a[WIDTH-2:0];
        mag_b     = op_b[WIDTH-2:0];
        nan_a     = (&op_a[WIDTH-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
        nan_b     = (&op_b[WIDTH-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);
        both_zero = (mag_a == '0) && (mag_b == '0);
    end

    // Sign-magnitude ordering with the unordered and equal-zero cases removed.
    always_comb begin
        if (nan_a || nan_b || both_zero)
            a_gt_b = 1'b0;
        else if (sgn_a != sgn_b)
            a_gt_b = sgn_b;
        else if (!sgn_a)
            a_gt_b = mag_a > mag_b;
        else
            a_gt_b = mag_a < mag_b;
    end
endmodule

// File: rtl/bf16cmp_decode.sv
// Maps the minor opcode to a predicate write mode.
// Codes outside the four defined ones are reported as illegal.
module bf16cmp_decode
    import bf16cmp_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output pmode_e          mode,
    output logic            illegal
);
    // Full compare of the opcode against each defined code.
    always_comb begin
        mode    = MODE_SET;
        illegal = 1'b0;
        unique case (opcode)
            OPC_SET: mode = MODE_SET;
            OPC_AND: mode = MODE_AND;
            OPC_OR:  mode = MODE_OR;
            OPC_XOR: mode = MODE_XOR;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bf16cmp_merge.sv
// Combines the compare mask with the old predicate according to the mode.
// An illegal opcode passes the old predicate through unchanged.
module bf16cmp_merge
    import bf16cmp_pkg::*;
#(
    parameter int PRED_W = 128
) (
    input  logic [PRED_W-1:0] cmp_mask,
    input  logic [PRED_W-1:0] old_pred,
    input  pmode_e            mode,
    input  logic              illegal,
    output logic [PRED_W-1:0] new_pred
);
    // Select the write operator bitwise over the whole predicate.
    always_comb begin
        if (illegal) begin
            new_pred = old_pred;
        end else begin
            unique case (mode)
                MODE_SET: new_pred = cmp_mask;
                MODE_AND: new_pred = old_pred & cmp_mask;
                MODE_OR:  new_pred = old_pred | cmp_mask;
                MODE_XOR: new_pred = old_pred ^ cmp_mask;
                default:  new_pred = old_pred;
            endcase
        end
    end
endmodule

// File: rtl/bf16_vcmp_pred.sv
// Top: lane-wise bf16 greater-than over a vector, widened to a byte predicate.
// Each lane spans LANE_W/8 bytes, and each byte owns one predicate bit.
// REG_OUT=1 adds one output register stage with a synchronous active-low reset.
module bf16_vcmp_pred
    import bf16cmp_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int LANE_W  = 16,
    parameter int EXP_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*LANE_W-1:0]  vec_a,
    input  logic [LANES*LANE_W-1:0]  vec_b,
    input  logic [LANES*LANE_W/8-1:0] pred_in,
    input  logic [OP_W-1:0]          minor_op,
    output logic [LANES*LANE_W/8-1:0] pred_out,
    output logic                     illegal_op
);
    localparam int BPL    = LANE_W / 8;
    localparam int PRED_W = LANES * BPL;

    logic [PRED_W-1:0] cmp_mask;
    logic [PRED_W-1:0] next_pred;
    pmode_e            mode;
    logic              illegal;

    // One comparator per lane, its result replicated over the lane's bytes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic gt;
        bf16_lane_gt #(.WIDTH(LANE_W), .EXP_W(EXP_W)) u_gt (
            .op_a   (vec_a[g*LANE_W +: LANE_W]),
            .op_b   (vec_b[g*LANE_W +: LANE_W]),
            .a_gt_b (gt)
        );
        assign cmp_mask[g*BPL +: BPL] = {BPL{gt}};
    end

    bf16cmp_decode u_dec (
        .opcode  (minor_op),
        .mode    (mode),
        .illegal (illegal)
    );

    bf16cmp_merge #(.PRED_W(PRED_W)) u_merge (
        .cmp_mask (cmp_mask),
        .old_pred (pred_in),
        .mode     (mode),
        .illegal  (illegal),
        .new_pred (next_pred)
    );

    if (REG_OUT) begin : g_reg
        // Register the result; reset clears the predicate and the flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pred_out   <= '0;
                illegal_op <= 1'b0;
            end else begin
                pred_out   <= next_pred;
                illegal_op <= illegal;
            end
        end
    end else begin : g_comb
        assign pred_out   = next_pred;
        assign illegal_op = illegal;
    end
endmodule

// File: rtl/bf16_vcmp_pred_chk.sv
// Checker for bf16_vcmp_pred in its registered form. It relates each output
// word to the inputs one clock earlier.
module bf16_vcmp_pred_chk
    import bf16cmp_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int LANE_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [LANES*LANE_W-1:0]   vec_a,
    input logic [LANES*LANE_W-1:0]   vec_b,
    input logic [LANES*LANE_W/8-1:0] pred_in,
    input logic [OP_W-1:0]           minor_op,
    input logic [LANES*LANE_W/8-1:0] pred_out,
    input logic                      illegal_op
);
    localparam int PRED_W = LANES * LANE_W / 8;

    logic [LANES-1:0] ev_bits, od_bits, delta_ev, delta_od;
    logic [PRED_W-1:0] prev_pred;

    // Keep the predicate input of the previous cycle for the merge checks.
    always_ff @(posedge clk) prev_pred <= pred_in;

    // Split the output and the change word into the lane's low and high bits.
    for (genvar g = 0; g < LANES; g++) begin : g_pair
        assign ev_bits[g]  = pred_out[2*g];
        assign od_bits[g]  = pred_out[2*g+1];
        assign delta_ev[g] = pred_out[2*g]   ^ prev_pred[2*g];
        assign delta_od[g] = pred_out[2*g+1] ^ prev_pred[2*g+1];
    end

    if (REG_OUT) begin : g_props
        // R8
        illegal_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && illegal_op) |-> (pred_out == prev_pred));

        // R2
        set_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(minor_op) == OPC_SET) |-> (ev_bits == od_bits));

        // R3
        and_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(minor_op) == OPC_AND) |-> ((pred_out & ~prev_pred) == '0));

        // R4
        or_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(minor_op) == OPC_OR) |-> ((~pred_out & prev_pred) == '0));

        // R5
        xor_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(minor_op) == OPC_XOR) |-> (delta_ev == delta_od));

        // R7
        equal_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(minor_op) == OPC_SET && $past(vec_a == vec_b))
            |-> (pred_out == '0));
    end
endmodule

bind bf16_vcmp_pred bf16_vcmp_pred_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vec_a(vec_a), .vec_b(vec_b),
    .pred_in(pred_in), .minor_op(minor_op),
    .pred_out(pred_out), .illegal_op(illegal_op)
);

// File: tb/bf16_vcmp_pred_test.sv
module bf16_vcmp_pred_test;
    localparam int LANES = 64;
    localparam int VW    = LANES * 16;
    localparam int PW    = LANES * 2;

    localparam logic [5:0] C_SET = 6'b011110;
    localparam logic [5:0] C_AND = 6'b110100;
    localparam logic [5:0] C_OR  = 6'b001110;
    localparam logic [5:0] C_XOR = 6'b111100;

    // {a, b, a>b}
    localparam logic [32:0] TBL [16] = '{
        {16'h3F80, 16'h3F00, 1'b1},  // R1 1.0 > 0.5
        {16'h3F00, 16'h3F80, 1'b0},  // R1 0.5 > 1.0
        {16'h3F80, 16'h3F80, 1'b0},  // R7 equal
        {16'h0000, 16'h8000, 1'b0},  // R7 +0 vs -0
        {16'h8000, 16'h0000, 1'b0},  // R7 -0 vs +0
        {16'hBF80, 16'hC000, 1'b1},  // R10 -1 > -2
        {16'hC000, 16'hBF80, 1'b0},  // R10 -2 > -1
        {16'h7F80, 16'h7F7F, 1'b1},  // R10 +inf > max finite
        {16'h7FC0, 16'h3F80, 1'b0},  // R6 NaN left
        {16'h3F80, 16'h7FC0, 1'b0},  // R6 NaN right
        {16'hFF81, 16'hFF80, 1'b0},  // R6 negative NaN vs -inf
        {16'h0001, 16'h0000, 1'b1},  // R10 denormal > +0
        {16'h0000, 16'h8001, 1'b1},  // R10 +0 > negative denormal
        {16'h3F80, 16'hBF80, 1'b1},  // R1 sign
        {16'hFF80, 16'h7F80, 1'b0},  // R10 -inf vs +inf
        {16'h7F81, 16'h7F81, 1'b0}   // R6 NaN vs itself
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vec_a = '0, vec_b = '0;
    logic [PW-1:0] pred_in = '0;
    logic [5:0]    minor_op = 6'b000000;
    logic [PW-1:0] pred_out;
    logic          illegal_op;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bf16_vcmp_pred uut (
        .clk(clk), .rst_n(rst_n), .vec_a(vec_a), .vec_b(vec_b),
        .pred_in(pred_in), .minor_op(minor_op),
        .pred_out(pred_out), .illegal_op(illegal_op)
    );

    task automatic check(input string tag, input logic [PW-1:0] exp_p, input logic exp_i);
        checks++;
        if (pred_out !== exp_p || illegal_op !== exp_i) begin
            errors++;
            $display("FAIL %s: pred_out=%h illegal_op=%b expected pred_out=%h illegal_op=%b",
                     tag, pred_out, illegal_op, exp_p, exp_i);
        end
    endtask

    // Drive at a falling edge; the result is sampled at the next falling edge.
    task automatic apply(input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [PW-1:0] p, input logic [5:0] op);
        @(negedge clk);
        vec_a = a; vec_b = b; pred_in = p; minor_op = op;
        @(negedge clk);
    endtask

    function automatic bit lane_sel(input int i, input int k);
        return ((i * 7 + k) % 3) != 0;
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        logic [VW-1:0] a, b;
        logic [PW-1:0] m, old;
        old = {4{32'hA5C3_0F69}};
        // R9 reset clears outputs even with an illegal opcode driven
        pred_in = '1; minor_op = 6'b000000;
        repeat (3) @(negedge clk);
        check("R9 reset", '0, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R6 R7 R10 table walk in assign mode
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < LANES; i++) begin
                a[i*16 +: 16] = lane_sel(i, k) ? TBL[k][32:17] : TBL[k][16:1];
                b[i*16 +: 16] = TBL[k][16:1];
                m[i*2 +: 2]   = (lane_sel(i, k) && TBL[k][0]) ? 2'b11 : 2'b00;
            end
            apply(a, b, old, C_SET);
            check($sformatf("R2 table entry %0d", k), m, 1'b0);
        end

        // Build a mixed mask from table entry 0 for the merge modes.
        for (int i = 0; i < LANES; i++) begin
            a[i*16 +: 16] = lane_sel(i, 0) ? 16'h3F80 : 16'h3F00;
            b[i*16 +: 16] = 16'h3F00;
            m[i*2 +: 2]   = lane_sel(i, 0) ? 2'b11 : 2'b00;
        end
        apply(a, b, old, C_AND);
        check("R3 and-merge", old & m, 1'b0);
        apply(a, b, old, C_OR);
        check("R4 or-merge", old | m, 1'b0);
        apply(a, b, old, C_XOR);
        check("R5 xor-merge", old ^ m, 1'b0);
        apply(a, b, ~old, C_XOR);
        check("R5 xor-merge inverted", ~old ^ m, 1'b0);

        // R1 single lane placement: only lane 37 true -> bits 74,75
        a = {LANES{16'h3F00}}; b = {LANES{16'h3F00}};
        a[37*16 +: 16] = 16'h4000;
        apply(a, b, '0, C_SET);
        check("R1 lane 37 mapping", PW'(3) << 74, 1'b0);

        // R8 unknown opcodes pass the predicate through
        apply(a, b, old, 6'b000000);
        check("R8 opcode 000000", old, 1'b1);
        apply(a, b, ~old, 6'b011111);
        check("R8 opcode 011111", ~old, 1'b1);

        // R9 latency: a new input does not reach the output before the edge
        @(negedge clk);
        vec_a = b; vec_b = a; pred_in = old; minor_op = C_SET;
        #1;
        check("R9 output held until clock", ~old, 1'b1);
        @(negedge clk);
        check("R9 one-cycle update", '0, 1'b0);

        // R9 mid-run reset
        @(negedge clk);
        rst_n = 1'b0; pred_in = old; minor_op = 6'b000001;
        @(negedge clk);
        check("R9 mid-run reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset release", old, 1'b1);

        report();
    end
endmodule